// File: doc/BRIEF.md
# Ones-Complement Adder/Subtractor with End-Around Carry

This block adds or subtracts two integers held in ones-complement form. A negative value is the bitwise inverse of its positive counterpart. To subtract, the block inverts the second operand and then adds. The adder does not drop the carry that leaves the top bit. It feeds that carry back into the least significant bit, which gives the correct ones-complement sum in a single pass.

Ones complement has two encodings of zero: all zeros (+0) and all ones (-0). The block flags every result that comes out as -0. A build-time option folds -0 into +0 on the data output, and the flag still reports that the fold took place. A second flag marks signed overflow.

All outputs come from one register stage. Each valid input produces a valid result one clock later.

Top module: `ones_comp_adder`

## Requirements
- R1: When `sub` is 1, the operation is `a` plus the bitwise inverse of `b`. When `sub` is 0, the operation is `a` plus `b`.
- R2: The result is the WIDTH-bit sum of the effective operands plus the carry out of bit WIDTH-1, added back in at bit 0. With the default width, for example, 0x90 + 0x90 gives 0x21.
- R3: With WIDTH = 8, adding 0x05 and 0xFC returns 0x02.
- R4: `neg_zero` is 1 exactly when the sum, before any folding, is all ones.
- R5: With NORMALIZE_ZERO = 1, an all-ones sum appears on `result` as all zeros, and `neg_zero` is still 1.
- R6: With NORMALIZE_ZERO = 0, an all-ones sum appears on `result` unchanged.
- R7: `overflow` is 1 when both effective operands have the same sign bit (bit WIDTH-1) and the sum's sign bit differs from it. For example, 0x7F + 0x01 and 0x80 + 0x80 both overflow, and 0x05 + 0xFC does not.
- R8: `out_valid` is 1 in the cycle after a clock edge that sampled `in_valid` = 1, and 0 after an edge that sampled `in_valid` = 0.
- R9: A clock edge with `rst` = 1 clears `result`, `out_valid`, `overflow` and `neg_zero` to 0.
- R10: While `in_valid` is 0, `result`, `overflow` and `neg_zero` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are valid this cycle |
| a | input | WIDTH | First operand, ones complement |
| b | input | WIDTH | Second operand, ones complement |
| sub | input | 1 | 1 selects a - b, 0 selects a + b |
| result | output | WIDTH | Registered sum or difference |
| out_valid | output | 1 | `result` and the flags are valid |
| overflow | output | 1 | Signed overflow on the last operation |
| neg_zero | output | 1 | The last sum was all ones before folding |

## Verification
A dropped or mis-routed end-around carry shows up as a result that is off by one. It appears only on operand pairs whose raw sum carries out, so the tests include both carrying and non-carrying pairs. Every fault in the datapath shows at the ports in the cycle right after the operands are sampled, because there is only one register stage. A fault in the fold path or the flag path reveals itself only on operand pairs that sum to -0, and on those the two build variants must differ on `result` while agreeing on `neg_zero`.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef struct packed {
    logic ovf;
    logic negz;
  } oc_flags_t;
endpackage

// File: rtl/oc_operand_prep.sv
module oc_operand_prep #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] b_eff
);
  function automatic logic [WIDTH-1:0] oc_negate(input logic [WIDTH-1:0] v);
    return ~v;
  endfunction

  assign b_eff = sub ? oc_negate(b) : b;
endmodule

// File: rtl/oc_eac_core.sv
module oc_eac_core #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b_eff,
  output logic [WIDTH-1:0] sum,
  output logic             wrap_carry,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  function automatic logic [WIDTH:0] raw_add(input logic [WIDTH-1:0] x,
                                             input logic [WIDTH-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [WIDTH-1:0] wrap_add(input logic [WIDTH:0] raw);
    return raw[WIDTH-1:0] + {{(WIDTH-1){1'b0}}, raw[WIDTH]};
  endfunction

  logic [WIDTH:0] raw;

  always_comb begin
    raw        = raw_add(a, b_eff);
    wrap_carry = raw[WIDTH];
    sum        = wrap_add(raw);
    ovf        = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end
endmodule

// File: rtl/oc_zero_fold.sv
module oc_zero_fold #(
  parameter int WIDTH          = 8,
  parameter bit NORMALIZE_ZERO = 1'b0
) (
  input  logic [WIDTH-1:0] raw_sum,
  output logic [WIDTH-1:0] folded,
  output logic             is_neg_zero
);
  assign is_neg_zero = &raw_sum;

  generate
    if (NORMALIZE_ZERO) begin : g_fold
      assign folded = is_neg_zero ? '0 : raw_sum;
    end else begin : g_pass
      assign folded = raw_sum;
    end
  endgenerate
endmodule

// File: rtl/ones_comp_adder.sv
module ones_comp_adder #(
  parameter int WIDTH          = 8,
  parameter bit NORMALIZE_ZERO = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] result,
  output logic             out_valid,
  output logic             overflow,
  output logic             neg_zero
);
  import oc_pkg::*;

  generate
    if (WIDTH < 2) begin : g_bad_width
      $error("ones_comp_adder: WIDTH must be at least 2");
    end
  endgenerate

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] pre_fold;
  logic [WIDTH-1:0] folded;
  logic             wrap_carry;
  oc_flags_t        flags_d;

  oc_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .b     (b),
    .sub   (sub),
    .b_eff (b_eff)
  );

  oc_eac_core #(.WIDTH(WIDTH)) u_core (
    .a          (a),
    .b_eff      (b_eff),
    .sum        (pre_fold),
    .wrap_carry (wrap_carry),
    .ovf        (flags_d.ovf)
  );

  oc_zero_fold #(.WIDTH(WIDTH), .NORMALIZE_ZERO(NORMALIZE_ZERO)) u_fold (
    .raw_sum     (pre_fold),
    .folded      (folded),
    .is_neg_zero (flags_d.negz)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      out_valid <= 1'b0;
      overflow  <= 1'b0;
      neg_zero  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= folded;
        overflow <= flags_d.ovf;
        neg_zero <= flags_d.negz;
      end
    end
  end
endmodule

// File: rtl/oc_adder_checker.sv
module oc_adder_checker #(
  parameter int WIDTH          = 8,
  parameter bit NORMALIZE_ZERO = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             wrap_carry,
  input logic [WIDTH-1:0] pre_fold,
  input logic [WIDTH-1:0] result,
  input logic             out_valid,
  input logic             overflow,
  input logic             neg_zero
);
  // R9: a reset edge leaves every output cleared
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && !overflow && !neg_zero));

  // R8: one-cycle latency from input strobe to output strobe
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r8_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R10: outputs hold while no operands arrive
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(overflow) && $stable(neg_zero)));

  // R5 / R6: a flagged -0 leaves the result folded or untouched per build option
  a_r5_fold_value: assert property (@(posedge clk) disable iff (rst)
    (out_valid && neg_zero) |-> (result == (NORMALIZE_ZERO ? '0 : '1)));

  // R2: a wrapped carry never leaves an all-zero sum
  a_r2_wrap_nonzero: assert property (@(posedge clk) disable iff (rst)
    wrap_carry |-> (pre_fold != '0));
endmodule

bind ones_comp_adder oc_adder_checker #(
  .WIDTH(WIDTH), .NORMALIZE_ZERO(NORMALIZE_ZERO)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .wrap_carry (wrap_carry),
  .pre_fold   (pre_fold),
  .result     (result),
  .out_valid  (out_valid),
  .overflow   (overflow),
  .neg_zero   (neg_zero)
);

// File: tb/sim_ones_comp_adder.sv
module sim_ones_comp_adder;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         sub = 1'b0;
  logic [W-1:0] res0, res1;
  logic         ov0, ov1, nz0, nz1, v0, v1;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ones_comp_adder #(.WIDTH(W), .NORMALIZE_ZERO(1'b0)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b), .sub(sub),
    .result(res0), .out_valid(v0), .overflow(ov0), .neg_zero(nz0));

  ones_comp_adder #(.WIDTH(W), .NORMALIZE_ZERO(1'b1)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b), .sub(sub),
    .result(res1), .out_valid(v1), .overflow(ov1), .neg_zero(nz1));

  // Reference model: the signed value of each ones-complement operand is
  // computed, then the sum is formed modulo 2^W - 1.
  function automatic int oc_val(input logic [W-1:0] x);
    return x[W-1] ? -int'((~x) & 8'hFF) : int'(x);
  endfunction

  function automatic logic [W-1:0] ref_sum(input logic [W-1:0] x, input logic [W-1:0] y);
    int s;
    s = int'(x) + int'(y);
    if (s >= 256) s = s - 255;
    return s[W-1:0];
  endfunction

  function automatic bit ref_ovf(input logic [W-1:0] x, input logic [W-1:0] y);
    int t;
    t = oc_val(x) + oc_val(y);
    return (t > 127) || (t < -127);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic s);
    @(negedge clk);
    a = x; b = y; sub = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk(res0 == 0 && !v0 && !ov0 && !nz0, "R9 reset u0", res0, 0);
    chk(res1 == 0 && !v1 && !ov1 && !nz1, "R9 reset u1", res1, 0);
  endtask

  task automatic t_example;
    apply(8'h05, 8'hFC, 1'b0);
    chk(res0 == 8'h02, "R3 5+FC", res0, 8'h02);
    chk(ov0 == 1'b0, "R7 no ovf 5+FC", ov0, 0);
  endtask

  task automatic t_sub;
    apply(8'h05, 8'h03, 1'b1);
    chk(res0 == 8'h02, "R1 5-3", res0, 8'h02);
    apply(8'h03, 8'h05, 1'b1);
    chk(res0 == 8'hFD, "R1 3-5", res0, 8'hFD);
    apply(8'h40, 8'h10, 1'b0);
    chk(res0 == 8'h50, "R1 add no invert", res0, 8'h50);
  endtask

  task automatic t_eac_sweep;
    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] x, y, e;
      logic s;
      x = W'((i * 37 + 11) & 8'hFF);
      y = W'((i * 91 + 200) & 8'hFF);
      s = i[0];
      apply(x, y, s);
      e = ref_sum(x, s ? ~y : y);
      chk(res0 == e, "R2 sweep", res0, e);
      chk(ov0 == ref_ovf(x, s ? ~y : y), "R7 sweep", ov0, ref_ovf(x, s ? ~y : y));
    end
    apply(8'h90, 8'h90, 1'b0);
    chk(res0 == 8'h21, "R2 90+90", res0, 8'h21);
  endtask

  task automatic t_negzero;
    apply(8'h05, 8'h05, 1'b1);
    chk(nz0 && nz1, "R4 5-5 flag", {nz0, nz1}, 2'b11);
    chk(res0 == 8'hFF, "R6 keep -0", res0, 8'hFF);
    chk(res1 == 8'h00, "R5 fold -0", res1, 8'h00);
    apply(8'h00, 8'h00, 1'b0);
    chk(!nz0 && res0 == 8'h00, "R4 +0 no flag", res0, 8'h00);
    apply(8'hFF, 8'h00, 1'b0);
    chk(nz1 && res1 == 8'h00, "R5 -0 plus +0", res1, 8'h00);
  endtask

  task automatic t_ovf;
    apply(8'h7F, 8'h01, 1'b0);
    chk(ov0 == 1'b1 && res0 == 8'h80, "R7 7F+01", {ov0, res0}, 9'h180);
    apply(8'h80, 8'h80, 1'b0);
    chk(ov0 == 1'b1 && res0 == 8'h01, "R7 80+80", {ov0, res0}, 9'h101);
    apply(8'h80, 8'hFF, 1'b0);
    chk(ov0 == 1'b0, "R7 80+FF", ov0, 0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    a = 8'h11; b = 8'h22; sub = 1'b0; in_valid = 1'b1;
    chk(!v0, "R8 not yet valid", v0, 0);
    @(negedge clk);
    chk(v0 && res0 == 8'h33, "R8 valid next cycle", {v0, res0}, 9'h133);
    in_valid = 1'b0;
    @(negedge clk);
    chk(!v0, "R8 drops after idle", v0, 0);
  endtask

  task automatic t_hold;
    apply(8'h05, 8'h05, 1'b1);
    @(negedge clk);
    a = 8'h12; b = 8'h34; sub = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(res0 == 8'hFF && nz0 && !ov0, "R10 hold u0", res0, 8'hFF);
    chk(res1 == 8'h00 && nz1, "R10 hold u1", res1, 8'h00);
  endtask

  task automatic t_reset_mid;
    apply(8'h7F, 8'h01, 1'b0);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    chk(res0 == 0 && !v0 && !ov0 && !nz0, "R9 reset mid-run", res0, 0);
    rst = 1'b0; in_valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    checks++;
    $display("FAIL R8 watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_example();
    t_sub();
    t_eac_sweep();
    t_negzero();
    t_ovf();
    t_latency();
    t_hold();
    t_reset_mid();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule